// File: doc/BRIEF.md
# Scratchpad Write-Verify-Copy Controller

This block is the byte-level command engine of a small serial nonvolatile memory. The bus master never writes the backing array directly. It first loads an eight-byte staging scratchpad, then reads the scratchpad back or checks a returned checksum to confirm the transfer, and finally orders a copy. The copy succeeds only if the master echoes the address and status bytes exactly. The backing array holds 128 bytes, modelled as registers, and is written one full eight-byte row at a time.

The master sends bytes on `rx_byte`, qualified by `rx_valid`. A one-cycle `frame_rst` pulse opens a new frame, and the first byte of the frame is the command. To fetch a response byte, the master pulses `tx_req`. The block answers on the next cycle with `tx_valid` and `tx_byte` when a byte is due. A combinational read port onto the backing array shows the committed memory contents.

Top module: `spv_ctrl`

## Requirements
- R1: After reset, the status byte reads 0x20 (partial-data flag set, accepted flag clear, offset 0). Both address registers, the scratchpad and every memory byte are zero, and `tx_valid` is low.
- R2: Write command 0x0F is followed by the address low byte, the address high byte and up to eight data bytes. The stored low address has bits 2:0 cleared. Data bytes fill scratchpad positions 0 to 7 in order, and the status offset field (bits 2:0) holds the index of the last byte received.
- R3: Once all eight data bytes of a write have arrived, two response bytes are available. They are the bitwise inverse of a CRC-16 with polynomial x^16+x^15+x^2+1, processed LSB first from a zero start, over the command byte, the address bytes exactly as sent and the data bytes. The low byte comes first. No response byte is available before that point.
- R4: Read command 0xAA returns, in this order: the stored low address, the high address, the status byte, then scratchpad bytes 0 to 7. The status byte has the accepted flag at bit 7 and the partial-data flag at bit 5, and all other bits above bit 2 read zero.
- R5: A write command sets the partial-data flag. Only the eighth data byte of a write clears it, so a write frame that ends early leaves the flag set.
- R6: A write command clears the accepted flag. A successful copy sets it.
- R7: Copy command 0x55 followed by the stored low address, high address and status byte, with the partial-data flag clear, writes all eight scratchpad bytes to memory row address-low bits 6:3.
- R8: A copy with any mismatching echo byte, or run while the partial-data flag is set, leaves memory and the accepted flag unchanged.
- R9: The block ignores bytes that follow an unknown command and bytes beyond a frame's expected length. It also ignores a `tx_req` when no response byte is due.
- R10: `tx_valid` is high for one cycle, the cycle after a `tx_req` that has a byte due, and at no other time.
- R11: `frame_rst` aborts the current frame and restarts the CRC from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, standing in for power-up |
| frame_rst | input | 1 | One-cycle pulse that opens a new frame |
| rx_valid | input | 1 | Qualifies `rx_byte` |
| rx_byte | input | 8 | Byte from the master |
| tx_req | input | 1 | Master asks for the next response byte |
| tx_valid | output | 1 | Response byte is present |
| tx_byte | output | 8 | Response byte |
| mem_raddr | input | 7 | Backing-array read address |
| mem_rdata | output | 8 | Backing-array read data (combinational) |

## Verification
The bench writes to an unaligned address (0x13) and checks two things. The returned CRC must still cover 0x13, and the stored address must read back as 0x10. A design that aligned the address before the CRC would return a wrong checksum, and a design that skipped alignment would copy to the wrong row. It also sends a copy with a wrong status echo, and a copy that follows a truncated write. A design that ignored the echo or the partial-data flag would corrupt memory rows that should stay zero. Finally, it aborts a write midway and repeats it, and it asks for bytes early, late and after an unknown command. This catches a CRC that survives a frame reset, as well as stray `tx_valid` pulses.

// File: rtl/spv_pkg.sv
package spv_pkg;
    localparam int BYTE_W    = 8;
    localparam int ROW_BYTES = 8;
    localparam int OFF_W     = $clog2(ROW_BYTES);
    localparam int ROW_W     = ROW_BYTES * BYTE_W;
    localparam int CRC_W     = 16;

    localparam logic [BYTE_W-1:0] CMD_WRITE = 8'h0F;
    localparam logic [BYTE_W-1:0] CMD_READ  = 8'hAA;
    localparam logic [BYTE_W-1:0] CMD_COPY  = 8'h55;

    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 16'hA001;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [2:0] {
        FR_CMD,
        FR_WRITE,
        FR_READ,
        FR_COPY,
        FR_SKIP
    } frame_e;

    typedef struct packed {
        frame_e             frame;
        logic [3:0]         rx_cnt;
        logic [3:0]         tx_cnt;
        logic [CRC_W-1:0]   crc;
        byte_t              ta_lo;
        byte_t              ta_hi;
        logic               pf;
        logic               aa;
        logic [OFF_W-1:0]   eoff;
        logic [ROW_W-1:0]   sp;
        logic               echo_ok;
        logic               tx_valid;
        byte_t              tx_byte;
    } ctrl_state_t;
endpackage

// File: rtl/spv_crc16.sv
module spv_crc16 #(
    parameter int                CW   = 16,
    parameter int                DW   = 8,
    parameter logic [CW-1:0]     POLY = 16'hA001
) (
    input  logic [CW-1:0] crc_in,
    input  logic [DW-1:0] data_in,
    output logic [CW-1:0] crc_out
);
    // Reflected (LSB-first) bitwise update, one byte per call.
    always_comb begin
        logic [CW-1:0] c;
        logic          fb;
        c = crc_in;
        for (int i = 0; i < DW; i++) begin
            fb = c[0] ^ data_in[i];
            c  = c >> 1;
            if (fb) c = c ^ POLY;
        end
        crc_out = c;
    end
endmodule

// File: rtl/spv_row_store.sv
module spv_row_store #(
    parameter int MEM_BYTES = 128,
    parameter int ROW_BYTES = 8,
    parameter int BYTE_W    = 8,
    localparam int ROWS     = MEM_BYTES / ROW_BYTES,
    localparam int ADDR_W   = $clog2(MEM_BYTES),
    localparam int OFF_W    = $clog2(ROW_BYTES),
    localparam int RIDX_W   = ADDR_W - OFF_W,
    localparam int RW       = ROW_BYTES * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RIDX_W-1:0] wr_row,
    input  logic [RW-1:0]     wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data
);
    logic [RW-1:0] rows_q [ROWS];
    logic [RW-1:0] rows_d [ROWS];

    generate
        for (genvar r = 0; r < ROWS; r++) begin : g_row
            always_comb begin
                rows_d[r] = rows_q[r];
                if (wr_en && (wr_row == RIDX_W'(r))) rows_d[r] = wr_data;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) rows_q[r] <= '0;
                else        rows_q[r] <= rows_d[r];
            end
        end
    endgenerate

    logic [RW-1:0] rd_row;
    assign rd_row  = rows_q[rd_addr[ADDR_W-1:OFF_W]];
    assign rd_data = rd_row[{rd_addr[OFF_W-1:0], 3'b000} +: BYTE_W];

    // R8: memory contents move only on a row write
    p_mem_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $stable(rd_addr)) |-> $stable(rd_data));
endmodule

// File: rtl/spv_ctrl.sv
module spv_ctrl
    import spv_pkg::*;
#(
    parameter int MEM_BYTES = 128,
    localparam int ADDR_W   = $clog2(MEM_BYTES),
    localparam int RIDX_W   = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_rst,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              tx_req,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic [ADDR_W-1:0] mem_raddr,
    output logic [7:0]        mem_rdata
);
    localparam logic [3:0] WR_LAST = 4'(2 + ROW_BYTES - 1);
    localparam logic [3:0] WR_DONE = 4'(2 + ROW_BYTES);
    localparam logic [3:0] RD_LEN  = 4'(3 + ROW_BYTES);
    localparam logic [3:0] CP_LEN  = 4'd3;

    ctrl_state_t st_q, st_d;
    logic [CRC_W-1:0] crc_next;
    logic             mem_we;
    byte_t            es_byte;
    logic [OFF_W-1:0] wr_idx;
    logic [OFF_W-1:0] rd_idx;

    spv_crc16 #(.CW(CRC_W), .DW(BYTE_W), .POLY(CRC_POLY_REFL)) u_crc (
        .crc_in  (st_q.crc),
        .data_in (rx_byte),
        .crc_out (crc_next)
    );

    spv_row_store #(.MEM_BYTES(MEM_BYTES), .ROW_BYTES(ROW_BYTES), .BYTE_W(BYTE_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_row  (st_q.ta_lo[ADDR_W-1:OFF_W]),
        .wr_data (st_q.sp),
        .rd_addr (mem_raddr),
        .rd_data (mem_rdata)
    );

    assign es_byte = {st_q.aa, 1'b0, st_q.pf, 2'b00, st_q.eoff};
    assign wr_idx  = OFF_W'(st_q.rx_cnt - 4'd2);
    assign rd_idx  = OFF_W'(st_q.tx_cnt - 4'd3);

    always_comb begin
        byte_t echo_exp;
        logic  echo_now;
        st_d          = st_q;
        st_d.tx_valid = 1'b0;
        mem_we        = 1'b0;
        echo_exp      = '0;
        echo_now      = 1'b0;

        if (frame_rst) begin
            st_d.frame   = FR_CMD;
            st_d.rx_cnt  = '0;
            st_d.tx_cnt  = '0;
            st_d.crc     = '0;
            st_d.echo_ok = 1'b1;
        end else begin
            if (rx_valid) begin
                unique case (st_q.frame)
                    FR_CMD: begin
                        st_d.crc    = crc_next;
                        st_d.rx_cnt = '0;
                        st_d.tx_cnt = '0;
                        if (rx_byte == CMD_WRITE) begin
                            st_d.frame = FR_WRITE;
                            st_d.pf    = 1'b1;
                            st_d.aa    = 1'b0;
                        end else if (rx_byte == CMD_READ) begin
                            st_d.frame = FR_READ;
                        end else if (rx_byte == CMD_COPY) begin
                            st_d.frame   = FR_COPY;
                            st_d.echo_ok = 1'b1;
                        end else begin
                            st_d.frame = FR_SKIP;
                        end
                    end
                    FR_WRITE: begin
                        if (st_q.rx_cnt < WR_DONE) begin
                            st_d.crc    = crc_next;
                            st_d.rx_cnt = st_q.rx_cnt + 4'd1;
                            if (st_q.rx_cnt == 4'd0) begin
                                st_d.ta_lo = {rx_byte[7:OFF_W], {OFF_W{1'b0}}};
                            end else if (st_q.rx_cnt == 4'd1) begin
                                st_d.ta_hi = rx_byte;
                            end else begin
                                st_d.sp[{wr_idx, 3'b000} +: BYTE_W] = rx_byte;
                                st_d.eoff = wr_idx;
                                if (st_q.rx_cnt == WR_LAST) st_d.pf = 1'b0;
                            end
                        end
                    end
                    FR_COPY: begin
                        if (st_q.rx_cnt < CP_LEN) begin
                            if (st_q.rx_cnt == 4'd0)      echo_exp = st_q.ta_lo;
                            else if (st_q.rx_cnt == 4'd1) echo_exp = st_q.ta_hi;
                            else                          echo_exp = es_byte;
                            echo_now     = st_q.echo_ok && (rx_byte == echo_exp);
                            st_d.echo_ok = echo_now;
                            st_d.rx_cnt  = st_q.rx_cnt + 4'd1;
                            if ((st_q.rx_cnt == CP_LEN - 4'd1) && echo_now && !st_q.pf) begin
                                mem_we  = 1'b1;
                                st_d.aa = 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end

            if (tx_req) begin
                if (st_q.frame == FR_READ && st_q.tx_cnt < RD_LEN) begin
                    st_d.tx_valid = 1'b1;
                    st_d.tx_cnt   = st_q.tx_cnt + 4'd1;
                    if (st_q.tx_cnt == 4'd0)      st_d.tx_byte = st_q.ta_lo;
                    else if (st_q.tx_cnt == 4'd1) st_d.tx_byte = st_q.ta_hi;
                    else if (st_q.tx_cnt == 4'd2) st_d.tx_byte = es_byte;
                    else                          st_d.tx_byte = st_q.sp[{rd_idx, 3'b000} +: BYTE_W];
                end else if (st_q.frame == FR_WRITE && st_q.rx_cnt == WR_DONE
                             && st_q.tx_cnt < 4'd2) begin
                    st_d.tx_valid = 1'b1;
                    st_d.tx_cnt   = st_q.tx_cnt + 4'd1;
                    st_d.tx_byte  = (st_q.tx_cnt == 4'd0) ? ~st_q.crc[7:0] : ~st_q.crc[15:8];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.frame   <= FR_CMD;
            st_q.pf      <= 1'b1;
            st_q.echo_ok <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign tx_valid = st_q.tx_valid;
    assign tx_byte  = st_q.tx_byte;

    // R10: a response byte only ever answers a request
    p_tx_answers_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));

    // R11: checksum restarts after a frame reset
    p_crc_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(frame_rst) |-> (st_q.crc == '0));

    // R5: the partial-data flag drops only on the last data byte of a write
    p_pf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.pf) |-> $past(rx_valid && !frame_rst && st_q.frame == FR_WRITE
                                 && st_q.rx_cnt == WR_LAST));

    // R6: accepted flag rises only together with a memory commit
    p_aa_by_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.aa) |-> $past(mem_we));

    // R7: a commit never happens outside a copy frame with a clean scratchpad
    p_copy_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_we) |-> ($past(st_q.frame) == FR_COPY && !$past(st_q.pf)));
endmodule

// File: tb/spv_ctrl_test.sv
module spv_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_rst = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       tx_req = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic [6:0] mem_raddr = '0;
    logic [7:0] mem_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // behavioural reference state
    int m_ta_lo, m_ta_hi, m_pf, m_aa, m_eoff;
    int m_sp [8];
    int m_mem [128];
    int m_frame;   // 0 cmd, 1 write, 2 read, 3 copy, 4 skip
    int m_rx, m_tx, m_crc, m_ok;

    spv_ctrl uut (
        .clk(clk), .rst_n(rst_n), .frame_rst(frame_rst),
        .rx_valid(rx_valid), .rx_byte(rx_byte),
        .tx_req(tx_req), .tx_valid(tx_valid), .tx_byte(tx_byte),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int crc_step(int crc, int b);
        int c = crc;
        for (int i = 0; i < 8; i++) begin
            if (((c ^ (b >> i)) & 1) != 0) c = (c >> 1) ^ 'hA001;
            else                           c = c >> 1;
        end
        return c & 'hFFFF;
    endfunction

    function automatic int m_es();
        return (m_aa << 7) | (m_pf << 5) | m_eoff;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_rx(int b);
        case (m_frame)
            0: begin
                m_crc = crc_step(m_crc, b); m_rx = 0; m_tx = 0;
                if (b == 'h0F) begin m_frame = 1; m_pf = 1; m_aa = 0; end
                else if (b == 'hAA) m_frame = 2;
                else if (b == 'h55) begin m_frame = 3; m_ok = 1; end
                else m_frame = 4;
            end
            1: if (m_rx < 10) begin
                m_crc = crc_step(m_crc, b);
                if (m_rx == 0) m_ta_lo = b & 'hF8;
                else if (m_rx == 1) m_ta_hi = b;
                else begin
                    m_sp[m_rx-2] = b; m_eoff = m_rx - 2;
                    if (m_rx == 9) m_pf = 0;
                end
                m_rx++;
            end
            3: if (m_rx < 3) begin
                int e;
                e = (m_rx == 0) ? m_ta_lo : (m_rx == 1) ? m_ta_hi : m_es();
                m_ok = (m_ok != 0 && b == e) ? 1 : 0;
                if (m_rx == 2 && m_ok != 0 && m_pf == 0) begin
                    for (int k = 0; k < 8; k++) m_mem[((m_ta_lo >> 3) & 15)*8 + k] = m_sp[k];
                    m_aa = 1;
                end
                m_rx++;
            end
            default: ;
        endcase
    endtask

    task automatic send(int b, string req);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = 8'(b);
        model_rx(b);
        @(negedge clk);
        rx_valid = 1'b0;
        check(tx_valid == 1'b0, req, tx_valid, 0);
    endtask

    task automatic new_frame();
        @(negedge clk);
        frame_rst = 1'b1;
        m_frame = 0; m_rx = 0; m_tx = 0; m_crc = 0; m_ok = 1;
        @(negedge clk);
        frame_rst = 1'b0;
        check(tx_valid == 1'b0, "R11", tx_valid, 0);
    endtask

    task automatic pull(string req);
        int ev, eb;
        ev = 0; eb = 0;
        @(negedge clk);
        tx_req = 1'b1;
        if (m_frame == 2 && m_tx < 11) begin
            ev = 1;
            eb = (m_tx == 0) ? m_ta_lo : (m_tx == 1) ? m_ta_hi :
                 (m_tx == 2) ? m_es() : m_sp[m_tx-3];
            m_tx++;
        end else if (m_frame == 1 && m_rx == 10 && m_tx < 2) begin
            ev = 1;
            eb = (m_tx == 0) ? (~m_crc & 'hFF) : ((~m_crc >> 8) & 'hFF);
            m_tx++;
        end
        @(negedge clk);
        tx_req = 1'b0;
        check(int'(tx_valid) == ev, "R10", tx_valid, ev);
        if (ev != 0) check(int'(tx_byte) == eb, req, tx_byte, eb);
    endtask

    task automatic check_row(int row, string req);
        for (int k = 0; k < 8; k++) begin
            mem_raddr = 7'(row*8 + k);
            #1;
            check(int'(mem_rdata) == m_mem[row*8+k], req, mem_rdata, m_mem[row*8+k]);
        end
    endtask

    task automatic read_all(string req);
        new_frame();
        send('hAA, req);
        for (int k = 0; k < 11; k++) pull(req);
        pull("R9");   // nothing more due
    endtask

    task automatic write_row(int lo, int hi, int seed, string req);
        new_frame();
        send('h0F, req);
        pull("R9");   // nothing due yet
        send(lo, req);
        send(hi, req);
        for (int k = 0; k < 8; k++) send((seed + 37*k) & 'hFF, req);
        pull("R3");
        pull("R3");
        pull("R9");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        m_ta_lo = 0; m_ta_hi = 0; m_pf = 1; m_aa = 0; m_eoff = 0;
        m_frame = 0; m_rx = 0; m_tx = 0; m_crc = 0; m_ok = 1;
        for (int k = 0; k < 8; k++) m_sp[k] = 0;
        for (int k = 0; k < 128; k++) m_mem[k] = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_valid == 1'b0, "R1", tx_valid, 0);
        check_row(0, "R1");
        check_row(15, "R1");
        read_all("R1");                     // status 0x20

        // R2 R3: unaligned address, CRC over address as sent
        write_row('h13, 'h00, 'h11, "R2");
        send('h99, "R9");                   // beyond frame length
        pull("R9");
        read_all("R4");                     // 0x10, 0x00, 0x07, data

        // R7 R6: good copy
        new_frame();
        send('h55, "R7"); send('h10, "R7"); send('h00, "R7"); send('h07, "R7");
        send('h07, "R9");
        check_row(2, "R7");
        read_all("R6");                     // status 0x87

        // R8: wrong status echo
        write_row('h20, 'h00, 'h5A, "R6");
        new_frame();
        send('h55, "R8"); send('h20, "R8"); send('h00, "R8"); send('h08, "R8");
        check_row(4, "R8");
        read_all("R8");

        // R5: truncated write, then copy with correct echo must not commit
        new_frame();
        send('h0F, "R5"); send('h30, "R5"); send('h01, "R5");
        send('hC1, "R5"); send('hC2, "R5"); send('hC3, "R5");
        read_all("R5");                     // status 0x22
        new_frame();
        send('h55, "R8"); send('h30, "R8"); send('h01, "R8"); send('h22, "R8");
        check_row(6, "R8");
        read_all("R8");

        // R9: unknown command swallows following bytes
        new_frame();
        send('h33, "R9"); send('h0F, "R9"); send('h48, "R9");
        pull("R9");
        read_all("R9");

        // R11: aborted write, then full write; CRC must restart
        new_frame();
        send('h0F, "R11"); send('h48, "R11");
        write_row('h48, 'h00, 'hE3, "R11");
        new_frame();
        send('h55, "R7"); send('h48, "R7"); send('h00, "R7"); send('h07, "R7");
        check_row(9, "R7");
        check_row(2, "R8");
        read_all("R4");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule